// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the single-cycle entry into an exception or interrupt handler for a simple 32-bit RISC core. It can be started in two ways. The core can raise a synchronous cause through a strobe and a 4-bit cause code. Otherwise the block raises an interrupt by itself when an external request or a tick-timer request is pending and the matching enable bit in the current status word is set.

On the clock edge that takes the entry, the block does all of the following together. It saves the return address, saves the faulting address for illegal instructions, and keeps a copy of the unchanged status word. It produces the new status word and the new power-management word, voids the load-reserve reservation, and issues the handler address along with a one-cycle taken pulse. The core loads its program counter from the vector when it sees that pulse, and it also clears its delay-slot flag.

A cause code that is not defined does not vector. The block raises a one-cycle error pulse instead and leaves all of its saved state as it was.

Top module: `exc_entry`

## Requirements
- R1: An active-high synchronous reset sets every output and saved register to zero.
- R2: On a taken entry, epc_o receives pc_i. For the system-call cause (code 12) it receives pc_i + 4 instead.
- R3: For the illegal-instruction cause (code 7), eear_o receives pc_i. For any other entry, eear_o keeps its value.
- R4: On a taken entry, esr_o receives sr_i exactly as it was before any bit is changed.
- R5: The new status sr_o is sr_i with these changes: bit 0 (supervisor) set; bits 1 (tick enable), 2 (interrupt enable), 5 (data MMU) and 6 (instruction MMU) cleared; all other bits kept. pm_o receives pm_i with bits 1 (doze) and 2 (sleep) cleared.
- R6: A taken entry sets lock_o to all ones. With no entry, lock_we_i loads lock_addr_i. When both happen in the same cycle, the entry wins.
- R7: With dslot_i high, the saved return address is lowered by 4 and sr_o bit 13 is set. With dslot_i low, sr_o bit 13 is cleared.
- R8: vec_o is the cause code shifted left by 8. It is ORed with base_i when base_en_i is high, and with 0xF0000000 when sr_i bit 14 is set.
- R9: An external request irq_i is taken as cause 8 only when sr_i bit 2 is set. A tick request tick_i is taken as cause 5 only when sr_i bit 1 is set. When both qualify, the tick wins.
- R10: A synchronous strobe entry_i takes precedence over any qualified interrupt in the same cycle, and cause_o reports the strobed code.
- R11: A strobe with cause code 0 or 15 gives err_o high for one cycle with taken_o low, and no saved register changes.
- R12: taken_o is high for exactly the one cycle after the edge that takes an entry. Saved outputs change only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| entry_i | input | 1 | Synchronous exception strobe |
| cause_i | input | 4 | Cause code for the strobe |
| pc_i | input | 32 | Current program counter |
| sr_i | input | 32 | Current status word |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| irq_i | input | 1 | External interrupt request |
| tick_i | input | 1 | Tick timer request |
| base_en_i | input | 1 | Configuration: vector base register present |
| base_i | input | 32 | Vector base register |
| pm_i | input | 4 | Current power-management word |
| lock_we_i | input | 1 | Load the reservation address |
| lock_addr_i | input | 32 | Reservation address to load |
| taken_o | output | 1 | Entry taken on the last edge |
| err_o | output | 1 | Undefined cause strobed on the last edge |
| cause_o | output | 4 | Cause of the last taken entry |
| vec_o | output | 32 | Handler address |
| epc_o | output | 32 | Saved return address |
| eear_o | output | 32 | Saved faulting address |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | New status word |
| pm_o | output | 4 | New power-management word |
| lock_o | output | 32 | Reservation address |

## Verification
Two things can happen in the same cycle: a synchronous strobe, and a qualified interrupt request (tick, external, or both). A second same-cycle case is a reservation load arriving on the edge that takes an entry. The bench drives each pair together on one edge. It judges the first case by cause_o, vec_o and epc_o, which must follow the strobed cause and not the interrupt. It judges the second case by lock_o, which must read all ones rather than the loaded address.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int AW     = 32,
  parameter int CW     = 4,
  parameter int PW     = 4,
  parameter int NCAUSE = 15,
  parameter int VSH    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          entry_i,
  input  logic [CW-1:0] cause_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] sr_i,
  input  logic          dslot_i,
  input  logic          irq_i,
  input  logic          tick_i,
  input  logic          base_en_i,
  input  logic [AW-1:0] base_i,
  input  logic [PW-1:0] pm_i,
  input  logic          lock_we_i,
  input  logic [AW-1:0] lock_addr_i,
  output logic          taken_o,
  output logic          err_o,
  output logic [CW-1:0] cause_o,
  output logic [AW-1:0] vec_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] eear_o,
  output logic [AW-1:0] esr_o,
  output logic [AW-1:0] sr_o,
  output logic [PW-1:0] pm_o,
  output logic [AW-1:0] lock_o
);
  localparam int B_SUP  = 0;
  localparam int B_TEN  = 1;
  localparam int B_IEN  = 2;
  localparam int B_DMMU = 5;
  localparam int B_IMMU = 6;
  localparam int B_DSX  = 13;
  localparam int B_HI   = 14;
  localparam int P_DOZE = 1;
  localparam int P_SLP  = 2;

  localparam logic [CW-1:0] C_TICK = CW'(5);
  localparam logic [CW-1:0] C_ILL  = CW'(7);
  localparam logic [CW-1:0] C_EXT  = CW'(8);
  localparam logic [CW-1:0] C_SYS  = CW'(12);

  localparam logic [AW-1:0] SR_CLR = (AW'(1) << B_TEN) | (AW'(1) << B_IEN) |
                                     (AW'(1) << B_DMMU) | (AW'(1) << B_IMMU) |
                                     (AW'(1) << B_DSX);
  localparam logic [PW-1:0] PM_CLR = (PW'(1) << P_DOZE) | (PW'(1) << P_SLP);
  localparam logic [AW-1:0] HI_PFX = {4'hF, {(AW-4){1'b0}}};
  localparam logic [AW-1:0] STEP   = AW'(4);

  logic          tick_ok, ext_ok, req, code_ok, go;
  logic [CW-1:0] code;
  logic [AW-1:0] epc_n, vec_n, sr_n;

  assign tick_ok = tick_i & sr_i[B_TEN];
  assign ext_ok  = irq_i & sr_i[B_IEN];
  assign req     = entry_i | tick_ok | ext_ok;
  assign code    = entry_i ? cause_i : (tick_ok ? C_TICK : C_EXT);
  assign code_ok = (code != '0) && (32'(code) < NCAUSE);
  assign go      = req & code_ok;

  assign epc_n = pc_i + ((code == C_SYS) ? STEP : '0) - (dslot_i ? STEP : '0);
  assign vec_n = (AW'(code) << VSH) | (base_en_i ? base_i : '0) |
                 (sr_i[B_HI] ? HI_PFX : '0);
  assign sr_n  = (sr_i & ~SR_CLR) | (AW'(1) << B_SUP) |
                 (dslot_i ? (AW'(1) << B_DSX) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o <= 1'b0;
      err_o   <= 1'b0;
      cause_o <= '0;
      vec_o   <= '0;
      epc_o   <= '0;
      eear_o  <= '0;
      esr_o   <= '0;
      sr_o    <= '0;
      pm_o    <= '0;
      lock_o  <= '0;
    end else begin
      taken_o <= go;
      err_o   <= req & ~code_ok;
      if (go) begin
        cause_o <= code;
        vec_o   <= vec_n;
        epc_o   <= epc_n;
        esr_o   <= sr_i;
        sr_o    <= sr_n;
        pm_o    <= pm_i & ~PM_CLR;
        if (code == C_ILL) eear_o <= pc_i;
      end
      if (go) lock_o <= '1;
      else if (lock_we_i) lock_o <= lock_addr_i;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW     = 32,
  parameter int CW     = 4,
  parameter int NCAUSE = 15
) (
  input logic          clk,
  input logic          rst,
  input logic          entry_i,
  input logic [CW-1:0] cause_i,
  input logic [AW-1:0] sr_i,
  input logic          dslot_i,
  input logic          taken_o,
  input logic          err_o,
  input logic [AW-1:0] epc_o,
  input logic [AW-1:0] esr_o,
  input logic [AW-1:0] sr_o,
  input logic [AW-1:0] lock_o
);
  p_err_excl_r11: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !taken_o);

  p_bad_cause_r11: assert property (@(posedge clk) disable iff (rst)
    (entry_i && ((cause_i == '0) || (32'(cause_i) >= NCAUSE))) |=> (err_o && !taken_o));

  p_status_r5: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (sr_o[0] && !sr_o[1] && !sr_o[2] && !sr_o[5] && !sr_o[6]));

  p_lock_r6: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (&lock_o));

  p_esr_r4: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (esr_o == $past(sr_i)));

  p_dslot_r7: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (sr_o[13] == $past(dslot_i)));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> $stable(epc_o));

  p_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    entry_i |=> (taken_o || err_o));
endmodule

bind exc_entry exc_entry_chk #(.AW(AW), .CW(CW), .NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst(rst), .entry_i(entry_i), .cause_i(cause_i), .sr_i(sr_i),
  .dslot_i(dslot_i), .taken_o(taken_o), .err_o(err_o), .epc_o(epc_o),
  .esr_o(esr_o), .sr_o(sr_o), .lock_o(lock_o)
);

// File: tb/tb_exc_entry.sv
`timescale 1ns/100ps
module tb_exc_entry;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        entry_i = 0, dslot_i = 0, irq_i = 0, tick_i = 0, base_en_i = 0, lock_we_i = 0;
  logic [3:0]  cause_i = 0, pm_i = 0;
  logic [31:0] pc_i = 0, sr_i = 0, base_i = 0, lock_addr_i = 0;
  logic        taken_o, err_o;
  logic [3:0]  cause_o, pm_o;
  logic [31:0] vec_o, epc_o, eear_o, esr_o, sr_o, lock_o;

  int checks = 0, errors = 0;
  logic [3:0]  m_cause = 0, m_pm = 0;
  logic [31:0] m_vec = 0, m_epc = 0, m_eear = 0, m_esr = 0, m_sr = 0, m_lock = 0;

  always #2.5 clk = ~clk;

  exc_entry dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, predict from the requirements, check after the edge.
  task automatic apply(input logic en, input logic [3:0] c, input logic [31:0] pc,
                       input logic [31:0] sr, input logic ds, input logic irq,
                       input logic tk, input logic be, input logic [31:0] base,
                       input logic [3:0] pm, input logic lwe, input logic [31:0] laddr);
    logic [3:0] code;
    logic req, ok;
    @(negedge clk);
    entry_i = en; cause_i = c; pc_i = pc; sr_i = sr; dslot_i = ds; irq_i = irq;
    tick_i = tk; base_en_i = be; base_i = base; pm_i = pm; lock_we_i = lwe; lock_addr_i = laddr;
    req  = en | (tk & sr[1]) | (irq & sr[2]);
    code = en ? c : ((tk & sr[1]) ? 4'd5 : 4'd8);
    ok   = req && code != 0 && code != 15;
    @(posedge clk); #1;
    if (ok) begin
      m_cause = code;
      m_epc   = pc + ((code == 12) ? 32'd4 : 32'd0) - (ds ? 32'd4 : 32'd0);
      if (code == 7) m_eear = pc;
      m_esr   = sr;
      m_sr    = (sr & ~32'h0000_2066) | 32'h1 | (ds ? 32'h2000 : 32'h0);
      m_pm    = pm & 4'b1001;
      m_vec   = ({28'd0, code} << 8) | (be ? base : 32'd0) | (sr[14] ? 32'hF000_0000 : 32'd0);
      m_lock  = 32'hFFFF_FFFF;
    end else if (lwe) m_lock = laddr;
    chk("R12 taken_o", {31'd0, taken_o}, {31'd0, ok});
    chk("R11 err_o", {31'd0, err_o}, {31'd0, req & ~ok});
    chk("R9/R10 cause_o", {28'd0, cause_o}, {28'd0, m_cause});
    chk("R2/R7 epc_o", epc_o, m_epc);
    chk("R3 eear_o", eear_o, m_eear);
    chk("R4 esr_o", esr_o, m_esr);
    chk("R5/R7 sr_o", sr_o, m_sr);
    chk("R5 pm_o", {28'd0, pm_o}, {28'd0, m_pm});
    chk("R8 vec_o", vec_o, m_vec);
    chk("R6 lock_o", lock_o, m_lock);
    @(negedge clk);
    entry_i = 0; irq_i = 0; tick_i = 0; lock_we_i = 0;
    @(posedge clk); #1;
    chk("R12 taken_o pulse ends", {31'd0, taken_o}, 32'd0);
    chk("R12 epc_o held", epc_o, m_epc);
  endtask

  task automatic t_reset();
    chk("R1 taken_o", {31'd0, taken_o}, 32'd0);
    chk("R1 err_o", {31'd0, err_o}, 32'd0);
    chk("R1 epc_o", epc_o, 32'd0);
    chk("R1 vec_o", vec_o, 32'd0);
    chk("R1 sr_o", sr_o, 32'd0);
    chk("R1 lock_o", lock_o, 32'd0);
  endtask

  task automatic t_all_causes();
    for (int c = 1; c < 15; c++)
      apply(1, 4'(c), 32'h0000_1000 + 32'(c) * 16, 32'hA5A5_8066 & ~32'h4000, 0, 0, 0, 0, 0, 4'hF, 0, 0);
  endtask

  task automatic t_dslot();
    apply(1, 4'd12, 32'h0000_2004, 32'h0000_0006, 1, 0, 0, 0, 0, 4'h6, 0, 0);
    apply(1, 4'd7, 32'h0000_3008, 32'h0000_2000, 1, 0, 0, 0, 0, 4'h0, 0, 0);
    apply(1, 4'd2, 32'h0000_4000, 32'h0000_2000, 0, 0, 0, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_vector();
    apply(1, 4'd6, 32'h100, 32'h0, 0, 0, 0, 1, 32'h0012_0000, 4'h0, 0, 0);
    apply(1, 4'd9, 32'h104, 32'h4000, 0, 0, 0, 0, 32'h0012_0000, 4'h0, 0, 0);
    apply(1, 4'd14, 32'h108, 32'h4000, 0, 0, 0, 1, 32'h0340_0000, 4'h0, 0, 0);
  endtask

  task automatic t_irq();
    apply(0, 0, 32'h200, 32'h0000_0004, 0, 1, 0, 0, 0, 4'h0, 0, 0);
    apply(0, 0, 32'h204, 32'h0000_0002, 0, 1, 0, 0, 0, 4'h0, 0, 0);
    apply(0, 0, 32'h208, 32'h0000_0002, 0, 0, 1, 0, 0, 4'h0, 0, 0);
    apply(0, 0, 32'h20C, 32'h0000_0004, 0, 0, 1, 0, 0, 4'h0, 0, 0);
    apply(0, 0, 32'h210, 32'h0000_0006, 0, 1, 1, 0, 0, 4'h0, 0, 0);
    apply(0, 0, 32'h214, 32'h0000_0006, 1, 1, 0, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_sync_vs_irq();
    apply(1, 4'd6, 32'h300, 32'h0000_0006, 0, 1, 1, 0, 0, 4'h0, 0, 0);
    apply(1, 4'd12, 32'h304, 32'h0000_0004, 0, 1, 0, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_invalid();
    apply(1, 4'd0, 32'h400, 32'h0000_0000, 0, 0, 0, 0, 0, 4'h0, 0, 0);
    apply(1, 4'd15, 32'h404, 32'h0000_0006, 1, 1, 1, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_lock();
    apply(0, 0, 32'h500, 32'h0, 0, 0, 0, 0, 0, 4'h0, 1, 32'h0000_ABC0);
    apply(1, 4'd11, 32'h504, 32'h0, 0, 0, 0, 0, 0, 4'h0, 1, 32'h0000_1234);
    apply(0, 0, 32'h508, 32'h0, 0, 0, 0, 0, 0, 4'h0, 1, 32'h0000_5670);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 0;
    t_all_causes();
    t_dslot();
    t_vector();
    t_irq();
    t_sync_vs_irq();
    t_invalid();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule